// File: doc/BRIEF.md
# Fully Associative Address Translation Buffer with Page Protection

This block translates virtual addresses into physical addresses for a processor, ahead of a physically addressed cache. It keeps a small set of page mappings. Each mapping pairs a virtual page number with a physical page number and carries three flags: a present flag, a read-only flag and an execute-only flag. A lookup compares the requested virtual page number against every stored mapping at once. The result appears in the same cycle, with no register on the lookup path. A hit whose access type the flags allow returns the physical address. This address is the stored physical page number joined to the untouched page offset.

Any other lookup returns a 2-bit fault code, which tells software what went wrong: the mapping is missing, the page is swapped out, or the access breaks the page's permissions. Software installs mappings through a refill port, and the block chooses the slot the new mapping goes into. A flush input invalidates every mapping in a single cycle.

Top module: `tlb_xlate`

## Requirements
- R1: After reset, no mapping is valid. Every lookup with `lk_valid` high returns fault code 01 (miss), with `lk_hit` low.
- R2: A cycle with `flush` high invalidates all mappings. From the next cycle on, every lookup returns fault 01 until a new refill is made.
- R3: A lookup that hits a present page with an allowed access gives fault 00 and `lk_hit` high in the same cycle. `lk_paddr` then equals the stored physical page number concatenated with `lk_vaddr[OFF_W-1:0]`. Access type encoding is 00 read, 01 write, 10 instruction fetch, and 11 behaves as read.
- R4: A lookup that hits a mapping whose present flag is clear returns fault 10.
- R5: On a read-only page, a write returns fault 11. Reads and fetches to that page translate normally.
- R6: On an execute-only page, reads and writes return fault 11. Fetches to that page translate normally.
- R7: When a page is both not present and violated by the access, fault 10 takes priority over fault 11.
- R8: A refill whose virtual page number is already held overwrites that mapping in place. The old physical page number is no longer returned.
- R9: When the refill page number is not already held, the refill takes the lowest-numbered invalid slot if one exists. The round-robin pointer does not move in that case.
- R10: When every slot is valid, a refill replaces the slot named by the round-robin pointer. The pointer starts at 0 after reset, advances by one per such replacement and wraps after ENTRIES-1. A flush does not reset the pointer.
- R11: When `flush` and `fill_en` are high in the same cycle, the flush wins and the refill is dropped.
- R12: With `lk_valid` low, `lk_fault` is 00, `lk_hit` is low and `lk_paddr` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Invalidate all mappings |
| lk_valid | input | 1 | Lookup request |
| lk_vaddr | input | VA_W | Virtual address to translate |
| lk_kind | input | 2 | Access type: 00 read, 01 write, 10 fetch, 11 read |
| lk_hit | output | 1 | Translation succeeded |
| lk_fault | output | 2 | 00 none, 01 miss, 10 not present, 11 protection |
| lk_paddr | output | PA_W | Physical address, zero unless `lk_hit` |
| fill_en | input | 1 | Install a mapping |
| fill_vpn | input | VA_W-OFF_W | Virtual page number to install |
| fill_ppn | input | PA_W-OFF_W | Physical page number to install |
| fill_present | input | 1 | Page resident in memory |
| fill_ro | input | 1 | Page is read-only |
| fill_xo | input | 1 | Page is execute-only |

## Verification
The assertions assume that software installs mappings only through the refill port. The match vector can then never hold two set bits, because a repeated page number replaces its old mapping. The assertions also assume that `lk_kind` is driven to a defined value whenever `lk_valid` is high. The stimulus respects both points. Every refill goes through the bench task, and several refills deliberately repeat a page number. Every lookup drives one of the four access codes, and the eviction tests use page numbers that differ from all earlier ones.

// File: rtl/tlb_xlate.sv
module tlb_xlate #(
  parameter int VA_W    = 32,
  parameter int PA_W    = 32,
  parameter int OFF_W   = 12,
  parameter int ENTRIES = 64
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  flush,
  input  logic                  lk_valid,
  input  logic [VA_W-1:0]       lk_vaddr,
  input  logic [1:0]            lk_kind,
  output logic                  lk_hit,
  output logic [1:0]            lk_fault,
  output logic [PA_W-1:0]       lk_paddr,
  input  logic                  fill_en,
  input  logic [VA_W-OFF_W-1:0] fill_vpn,
  input  logic [PA_W-OFF_W-1:0] fill_ppn,
  input  logic                  fill_present,
  input  logic                  fill_ro,
  input  logic                  fill_xo
);
  localparam int VPN_W = VA_W - OFF_W;
  localparam int PPN_W = PA_W - OFF_W;
  localparam int IW    = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam logic [IW-1:0] LAST = IW'(ENTRIES - 1);

  localparam logic [1:0] K_WRITE = 2'b01;
  localparam logic [1:0] K_FETCH = 2'b10;
  localparam logic [1:0] F_NONE  = 2'b00;
  localparam logic [1:0] F_MISS  = 2'b01;
  localparam logic [1:0] F_ABSENT = 2'b10;
  localparam logic [1:0] F_PROT  = 2'b11;

  logic [VPN_W-1:0] vpn_q  [ENTRIES];
  logic [PPN_W-1:0] ppn_q  [ENTRIES];
  logic [ENTRIES-1:0] val_q, pres_q, ro_q, xo_q;
  logic [IW-1:0] rr_q;

  logic [VPN_W-1:0] lk_vpn;
  logic [ENTRIES-1:0] lk_match, fill_match;
  assign lk_vpn = lk_vaddr[VA_W-1:OFF_W];

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign lk_match[g]   = val_q[g] && (vpn_q[g] == lk_vpn);
    assign fill_match[g] = val_q[g] && (vpn_q[g] == fill_vpn);
  end

  logic [PPN_W-1:0] sel_ppn;
  logic sel_pres, sel_ro, sel_xo;
  always_comb begin
    sel_ppn  = '0;
    sel_pres = 1'b0;
    sel_ro   = 1'b0;
    sel_xo   = 1'b0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (lk_match[i]) begin
        sel_ppn  = sel_ppn | ppn_q[i];
        sel_pres = sel_pres | pres_q[i];
        sel_ro   = sel_ro | ro_q[i];
        sel_xo   = sel_xo | xo_q[i];
      end
    end
  end

  logic any_hit, prot_bad;
  assign any_hit  = |lk_match;
  assign prot_bad = (sel_ro && lk_kind == K_WRITE) || (sel_xo && lk_kind != K_FETCH);

  assign lk_fault = !lk_valid ? F_NONE   :
                    !any_hit  ? F_MISS   :
                    !sel_pres ? F_ABSENT :
                    prot_bad  ? F_PROT   : F_NONE;
  assign lk_hit   = lk_valid && any_hit && sel_pres && !prot_bad;
  assign lk_paddr = lk_hit ? {sel_ppn, lk_vaddr[OFF_W-1:0]} : '0;

  logic [IW-1:0] fm_idx, inv_idx, victim;
  logic fm_any, inv_any, use_rr;
  always_comb begin
    fm_idx  = '0;
    inv_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (fill_match[i]) fm_idx = IW'(i);
      if (!val_q[i])     inv_idx = IW'(i);
    end
  end
  assign fm_any  = |fill_match;
  assign inv_any = ~&val_q;
  assign use_rr  = !fm_any && !inv_any;
  assign victim  = fm_any ? fm_idx : (inv_any ? inv_idx : rr_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      val_q <= '0;
      rr_q  <= '0;
    end else if (flush) begin
      val_q <= '0;
    end else if (fill_en) begin
      val_q[victim] <= 1'b1;
      if (use_rr) rr_q <= (rr_q == LAST) ? '0 : rr_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst_n && !flush && fill_en) begin
      vpn_q[victim]  <= fill_vpn;
      ppn_q[victim]  <= fill_ppn;
      pres_q[victim] <= fill_present;
      ro_q[victim]   <= fill_ro;
      xo_q[victim]   <= fill_xo;
    end
  end

  // R8
  single_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lk_match));

  // R2
  flush_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !(lk_valid && lk_fault != F_MISS));

  // R3
  fill_then_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_en && !flush) |=> !(lk_valid && lk_vpn == $past(fill_vpn) && lk_fault == F_MISS));

  // R5
  fetch_no_prot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && lk_kind == K_FETCH) |-> lk_fault != F_PROT);

  // R10
  rr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(fill_en && !flush) |=> $stable(rr_q));

  // R12
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |-> (!lk_hit && lk_paddr == '0));
endmodule

// File: tb/sim_tlb_xlate.sv
module sim_tlb_xlate;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic flush = 1'b0;
  logic lk_valid = 1'b0;
  logic [31:0] lk_vaddr = '0;
  logic [1:0] lk_kind = '0;
  logic lk_hit;
  logic [1:0] lk_fault;
  logic [31:0] lk_paddr;
  logic fill_en = 1'b0;
  logic [19:0] fill_vpn = '0;
  logic [19:0] fill_ppn = '0;
  logic fill_present = 1'b0, fill_ro = 1'b0, fill_xo = 1'b0;

  int checks = 0;
  int fails = 0;

  always #5 clk = ~clk;

  tlb_xlate u0 (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .lk_valid(lk_valid), .lk_vaddr(lk_vaddr), .lk_kind(lk_kind),
    .lk_hit(lk_hit), .lk_fault(lk_fault), .lk_paddr(lk_paddr),
    .fill_en(fill_en), .fill_vpn(fill_vpn), .fill_ppn(fill_ppn),
    .fill_present(fill_present), .fill_ro(fill_ro), .fill_xo(fill_xo)
  );

  // {vaddr, kind, expected fault, expected paddr}
  localparam int NV = 13;
  localparam logic [67:0] VEC [NV] = '{
    {32'h0001_0123, 2'b00, 2'b00, 32'h00AA_0123}, // R3 read
    {32'h0001_0FFF, 2'b01, 2'b00, 32'h00AA_0FFF}, // R3 write
    {32'h0001_0000, 2'b10, 2'b00, 32'h00AA_0000}, // R3 fetch
    {32'h0002_0456, 2'b00, 2'b00, 32'h00BB_0456}, // R5 read ok
    {32'h0002_0456, 2'b01, 2'b11, 32'h0000_0000}, // R5 write blocked
    {32'h0002_0010, 2'b10, 2'b00, 32'h00BB_0010}, // R5 fetch ok
    {32'h0003_0789, 2'b10, 2'b00, 32'h00CC_0789}, // R6 fetch ok
    {32'h0003_0789, 2'b00, 2'b11, 32'h0000_0000}, // R6 read blocked
    {32'h0003_0789, 2'b01, 2'b11, 32'h0000_0000}, // R6 write blocked
    {32'h0004_0001, 2'b00, 2'b10, 32'h0000_0000}, // R4 absent
    {32'h0004_0001, 2'b01, 2'b10, 32'h0000_0000}, // R7 absent beats prot
    {32'h0005_0000, 2'b00, 2'b01, 32'h0000_0000}, // R3 unmapped miss
    {32'h0002_0456, 2'b11, 2'b00, 32'h00BB_0456}  // R3 kind 11 as read
  };

  task automatic check(input string req, input logic [1:0] f, input logic [31:0] pa,
                       input logic [1:0] ef, input logic [31:0] epa);
    checks++;
    if (f !== ef || pa !== epa) begin
      fails++;
      $display("FAIL %s: fault=%b paddr=%h expected fault=%b paddr=%h", req, f, pa, ef, epa);
    end
  endtask

  task automatic look(input logic [31:0] va, input logic [1:0] k,
                      input logic [1:0] ef, input logic [31:0] epa, input string req);
    @(negedge clk);
    lk_valid = 1'b1; lk_vaddr = va; lk_kind = k;
    #2;
    check(req, lk_fault, lk_paddr, ef, epa);
    lk_valid = 1'b0;
  endtask

  task automatic fill(input logic [19:0] v, input logic [19:0] p,
                      input logic pr, input logic ro, input logic xo);
    @(negedge clk);
    fill_en = 1'b1; fill_vpn = v; fill_ppn = p;
    fill_present = pr; fill_ro = ro; fill_xo = xo;
    @(negedge clk);
    fill_en = 1'b0;
  endtask

  task automatic do_flush();
    @(negedge clk); flush = 1'b1;
    @(negedge clk); flush = 1'b0;
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog: run did not complete");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    look(32'h0001_0123, 2'b00, 2'b01, 32'h0, "R1 reset miss");

    fill(20'h00010, 20'h00AA0, 1'b1, 1'b0, 1'b0);
    fill(20'h00020, 20'h00BB0, 1'b1, 1'b1, 1'b0);
    fill(20'h00030, 20'h00CC0, 1'b1, 1'b0, 1'b1);
    fill(20'h00040, 20'h00DD0, 1'b0, 1'b1, 1'b0);
    for (int i = 0; i < NV; i++) begin
      logic [67:0] v;
      string rq;
      v = VEC[i];
      rq = (v[33:32] == 2'b10) ? "R4" : (v[33:32] == 2'b11) ? "R5/R6" : "R3";
      look(v[67:36], v[35:34], v[33:32], v[31:0], rq);
    end

    // R12 idle lookup
    @(negedge clk);
    lk_valid = 1'b0; lk_vaddr = 32'h0001_0123; lk_kind = 2'b00;
    #2;
    checks++;
    if (lk_fault !== 2'b00 || lk_hit !== 1'b0 || lk_paddr !== 32'h0) begin
      fails++;
      $display("FAIL R12: fault=%b hit=%b paddr=%h expected 00 0 0", lk_fault, lk_hit, lk_paddr);
    end

    // R8 overwrite in place
    fill(20'h00010, 20'h00EE0, 1'b1, 1'b0, 1'b0);
    look(32'h0001_0042, 2'b00, 2'b00, 32'h00EE_0042, "R8 overwrite");

    // R2 flush
    do_flush();
    look(32'h0001_0042, 2'b00, 2'b01, 32'h0, "R2 flush miss");
    look(32'h0002_0000, 2'b10, 2'b01, 32'h0, "R2 flush miss");

    // R11 flush beats fill
    fill(20'h00060, 20'h00123, 1'b1, 1'b0, 1'b0);
    @(negedge clk);
    flush = 1'b1; fill_en = 1'b1; fill_vpn = 20'h00070; fill_ppn = 20'h00456;
    fill_present = 1'b1; fill_ro = 1'b0; fill_xo = 1'b0;
    @(negedge clk);
    flush = 1'b0; fill_en = 1'b0;
    look(32'h0007_0000, 2'b00, 2'b01, 32'h0, "R11 fill dropped");
    look(32'h0006_0000, 2'b00, 2'b01, 32'h0, "R11 flushed");

    // R9 invalid slots first, R10 round robin
    do_flush();
    for (int i = 0; i < 64; i++) fill(20'h00100 + 20'(i), 20'h00200 + 20'(i), 1'b1, 1'b0, 1'b0);
    look(32'h0013_F000, 2'b00, 2'b00, 32'h0023_F000, "R9 all slots used");
    fill(20'h00999, 20'h00888, 1'b1, 1'b0, 1'b0);
    look(32'h0010_0000, 2'b00, 2'b01, 32'h0, "R10 slot0 evicted");
    look(32'h0010_1000, 2'b00, 2'b00, 32'h0020_1000, "R10 slot1 kept");
    look(32'h0099_9ABC, 2'b00, 2'b00, 32'h0088_8ABC, "R10 new entry");
    fill(20'h00998, 20'h00887, 1'b1, 1'b0, 1'b0);
    look(32'h0010_1000, 2'b00, 2'b01, 32'h0, "R10 slot1 evicted");
    look(32'h0010_2000, 2'b00, 2'b00, 32'h0020_2000, "R10 slot2 kept");

    do_flush();
    for (int i = 0; i < 64; i++) fill(20'h00300 + 20'(i), 20'h00400 + 20'(i), 1'b1, 1'b0, 1'b0);
    fill(20'h00777, 20'h00666, 1'b1, 1'b0, 1'b0);
    look(32'h0030_0000, 2'b00, 2'b00, 32'h0040_0000, "R10 pointer kept over flush");
    look(32'h0030_1000, 2'b00, 2'b00, 32'h0040_1000, "R9 pointer held on invalid fill");
    look(32'h0030_2000, 2'b00, 2'b01, 32'h0, "R10 slot2 evicted");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule